// File: doc/BRIEF.md
# DMA Global Control and Status Register

This block is the global operation register of a four-channel DMA controller. It stores a master transfer enable and two sticky fault flags, one raised by a non-maskable interrupt event and one raised by a bus address-error event. From these three bits, and from each channel's own enable (DE) and transfer-end (TE) inputs, it derives a registered per-channel transfer permission and a global suspend indication. The channel engines consume these signals.

Software reaches the register through a simple select/read/write port. The master enable can be read and written freely. The two flags can only be set by their events. A flag clears only when software writes 0 to it after a register read has returned that flag as 1. Each flag keeps a private arm bit to record that read. If a new event arrives, it beats a clearing write in the same cycle and also removes the arm, so software must read the flag again before it can clear it.

Top module: `dma_gctl`

## Requirements
- R1: After the asynchronous reset is released: master enable is 0, both flags are 0, every `ch_en` bit is 0, `dma_suspend` is 1 and `reg_rdata` is 0.
- R2: The register layout is as follows. Bit 0 is the master enable, bit 1 is the NMI flag, bit 2 is the address-error flag, and bits 31:3 read as 0. `reg_rdata` takes the register value one cycle after a read strobe (`reg_sel` and `reg_rd`) and holds it until the next read.
- R3: A write (`reg_sel` and `reg_wr`) loads bit 0 of `reg_wdata` into the master enable at the next edge.
- R4: A cycle with `nmi_evt` high sets the NMI flag at the next edge, whether the master enable is 0 or 1.
- R5: Writing 1 to a flag bit never sets that flag.
- R6: Writing 0 to a flag clears it only if a read has returned that flag as 1 since it was last set. Otherwise the flag is unchanged.
- R7: An event in the same cycle as a valid clearing write leaves the flag at 1. Every event also discards the arm, so a following write of 0 without a new read leaves the flag at 1.
- R8: `ch_en[i]` is 1 exactly when the master enable is 1, `ch_de[i]` is 1, `ch_te[i]` is 0 and both flags are 0. It updates at the same edge as the register, one cycle after its inputs.
- R9: `dma_suspend` is 1 exactly when the master enable is 0 or either flag is 1. While it is 1, every `ch_en` bit is 0.
- R10: A cycle with `ae_evt` high sets the address-error flag at the next edge. That flag follows the same read-then-write-0 clearing rule as the NMI flag.
- R11: A cycle with `man_rst` high clears the master enable, both flags, both arm bits and `reg_rdata` at the next edge. It also drives `ch_en` to 0 and `dma_suspend` to 1, and it takes priority over events and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| man_rst | input | 1 | Synchronous manual reset, active high |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe, qualified by `reg_sel` |
| reg_rd | input | 1 | Read strobe, qualified by `reg_sel` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| nmi_evt | input | 1 | NMI event, one per cycle high |
| ae_evt | input | 1 | Address-error event, one per cycle high |
| ch_de | input | 4 | Per-channel enable bits |
| ch_te | input | 4 | Per-channel transfer-end bits |
| ch_en | output | 4 | Registered per-channel transfer permission |
| dma_suspend | output | 1 | Registered global suspend |

## Verification
Every result of this block appears one edge after its cause. Read data follows the read strobe by one cycle. A flag set, a flag clear or an enable change becomes visible on `ch_en` and `dma_suspend` at the edge that captures the stimulus. A flag's new value can be observed through `reg_rdata` one cycle after the next read strobe. The driver tasks apply each stimulus just after a rising edge and record the cycle in which each expected item is due. The monitor compares only in that cycle, at the falling edge. Any item still in the queue at the end counts as a mismatch.

// File: rtl/dma_gctl_pkg.sv
package dma_gctl_pkg;
  localparam int REG_W    = 32;
  localparam int ME_POS   = 0;
  localparam int NMI_POS  = 1;
  localparam int AE_POS   = 2;
  localparam int FLAG_CNT = 2;

  typedef enum logic [0:0] {
    FLG_NMI = 1'b0,
    FLG_AE  = 1'b1
  } flag_idx_e;

  function automatic int flag_pos(input int idx);
    return (idx == int'(FLG_NMI)) ? NMI_POS : AE_POS;
  endfunction
endpackage

// File: rtl/dma_gctl_flag.sv
module dma_gctl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic man_rst,
  input  logic set_evt,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic flag_d,
  output logic flag_q,
  output logic arm_q
);
  logic arm_d;
  logic upd_en;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (man_rst) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (set_evt) begin
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (wr_hit && !wr_bit && arm_q && flag_q) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (rd_hit && flag_q) begin
      arm_d  = 1'b1;
    end
  end

  assign upd_en = man_rst | set_evt | wr_hit | rd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end
endmodule

// File: rtl/dma_gctl_chgate.sv
module dma_gctl_chgate #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            permit_d,
  input  logic [N_CH-1:0] ch_de,
  input  logic [N_CH-1:0] ch_te,
  output logic [N_CH-1:0] ch_en
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic en_d;
    assign en_d = permit_d & ch_de[c] & ~ch_te[c];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_en[c] <= 1'b0;
      else        ch_en[c] <= en_d;
    end
  end
endmodule

// File: rtl/dma_gctl.sv
module dma_gctl
  import dma_gctl_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             man_rst,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             nmi_evt,
  input  logic             ae_evt,
  input  logic [N_CH-1:0]  ch_de,
  input  logic [N_CH-1:0]  ch_te,
  output logic [N_CH-1:0]  ch_en,
  output logic             dma_suspend
);
  logic                wr_hit;
  logic                rd_hit;
  logic                me_d;
  logic                me_q;
  logic [FLAG_CNT-1:0] evt_vec;
  logic [FLAG_CNT-1:0] flag_d;
  logic [FLAG_CNT-1:0] flag_q;
  logic [FLAG_CNT-1:0] arm_q;
  logic [REG_W-1:0]    reg_view;
  logic [REG_W-1:0]    rdata_d;
  logic                rdata_en;
  logic                permit_d;
  logic                susp_d;

  assign wr_hit = reg_sel & reg_wr;
  assign rd_hit = reg_sel & reg_rd;

  assign evt_vec[FLG_NMI] = nmi_evt;
  assign evt_vec[FLG_AE]  = ae_evt;

  for (genvar f = 0; f < FLAG_CNT; f++) begin : g_flag
    dma_gctl_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .man_rst (man_rst),
      .set_evt (evt_vec[f]),
      .rd_hit  (rd_hit),
      .wr_hit  (wr_hit),
      .wr_bit  (reg_wdata[flag_pos(f)]),
      .flag_d  (flag_d[f]),
      .flag_q  (flag_q[f]),
      .arm_q   (arm_q[f])
    );
  end

  // Master enable: plain read/write bit
  always_comb begin
    me_d = me_q;
    if (man_rst)     me_d = 1'b0;
    else if (wr_hit) me_d = reg_wdata[ME_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 me_q <= 1'b0;
    else if (man_rst || wr_hit) me_q <= me_d;
  end

  // Read view and registered read data
  always_comb begin
    reg_view          = '0;
    reg_view[ME_POS]  = me_q;
    reg_view[NMI_POS] = flag_q[FLG_NMI];
    reg_view[AE_POS]  = flag_q[FLG_AE];
  end

  assign rdata_en = man_rst | rd_hit;
  assign rdata_d  = man_rst ? '0 : reg_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        reg_rdata <= '0;
    else if (rdata_en) reg_rdata <= rdata_d;
  end

  // Global permission from next-state values, so gating shares the register edge
  assign permit_d = me_d & ~(|flag_d) & ~man_rst;
  assign susp_d   = ~permit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_suspend <= 1'b1;
    else        dma_suspend <= susp_d;
  end

  dma_gctl_chgate #(.N_CH(N_CH)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .permit_d (permit_d),
    .ch_de    (ch_de),
    .ch_te    (ch_te),
    .ch_en    (ch_en)
  );
endmodule

// File: rtl/dma_gctl_chk.sv
module dma_gctl_chk #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            man_rst,
  input logic            reg_sel,
  input logic            reg_wr,
  input logic [31:0]     reg_wdata,
  input logic [31:0]     reg_rdata,
  input logic            nmi_evt,
  input logic            ae_evt,
  input logic [N_CH-1:0] ch_en,
  input logic            dma_suspend,
  input logic            me_q,
  input logic [1:0]      flag_q,
  input logic [1:0]      arm_q
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:3] == '0); // R2

  AST_ME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && !man_rst) |=> (me_q == $past(reg_wdata[0]))); // R3

  AST_NMI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_evt && !man_rst) |=> flag_q[0]); // R4

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_evt && !flag_q[0]) |=> !flag_q[0]); // R5

  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !arm_q[0] && !man_rst) |=> flag_q[0]); // R6

  AST_EVT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_evt || man_rst) |=> !arm_q[0]); // R7

  AST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en != '0) |-> (me_q && flag_q == 2'b00)); // R8

  AST_SUSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    dma_suspend |-> (ch_en == '0)); // R9

  AST_AE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ae_evt && !man_rst) |=> flag_q[1]); // R10

  AST_MRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst |=> (!me_q && flag_q == 2'b00 && ch_en == '0 && dma_suspend)); // R11
endmodule

bind dma_gctl dma_gctl_chk #(.N_CH(N_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .man_rst     (man_rst),
  .reg_sel     (reg_sel),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .nmi_evt     (nmi_evt),
  .ae_evt      (ae_evt),
  .ch_en       (ch_en),
  .dma_suspend (dma_suspend),
  .me_q        (me_q),
  .flag_q      (flag_q),
  .arm_q       (arm_q)
);

// File: tb/test_dma_gctl.sv
`timescale 1ns/1ps
module test_dma_gctl;
  localparam int N_CH = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            man_rst = 1'b0;
  logic            reg_sel = 1'b0;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            nmi_evt = 1'b0;
  logic            ae_evt = 1'b0;
  logic [N_CH-1:0] ch_de = 4'b1011;
  logic [N_CH-1:0] ch_te = 4'b0010;
  logic [N_CH-1:0] ch_en;
  logic            dma_suspend;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_gctl #(.N_CH(N_CH)) i_dma_gctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .man_rst     (man_rst),
    .reg_sel     (reg_sel),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .nmi_evt     (nmi_evt),
    .ae_evt      (ae_evt),
    .ch_de       (ch_de),
    .ch_te       (ch_te),
    .ch_en       (ch_en),
    .dma_suspend (dma_suspend)
  );

  // Monitor: compare every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [31:0] act;
        case (sb[i].kind)
          0:       act = reg_rdata;
          1:       act = {28'd0, ch_en};
          default: act = {31'd0, dma_suspend};
        endcase
        n_cmp++;
        if (act !== sb[i].exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h cycle=%0d",
                   sb[i].tag, sb[i].kind, act, sb[i].exp, cyc);
        end
        sb.delete(i);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(int kind, logic [31:0] exp, string tag, int lag);
    item_t it;
    it.due = cyc + lag;
    it.kind = kind;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_out(logic [3:0] en, logic susp, string tag);
    push(1, {28'd0, en}, tag, 0);
    push(2, {31'd0, susp}, tag, 0);
  endtask

  task automatic rd(logic [31:0] exp, string tag);
    reg_sel = 1'b1;
    reg_rd  = 1'b1;
    push(0, exp, tag, 1);
    tick();
    reg_sel = 1'b0;
    reg_rd  = 1'b0;
  endtask

  task automatic wr(logic [31:0] d, logic nmi = 1'b0, logic ae = 1'b0);
    reg_sel   = 1'b1;
    reg_wr    = 1'b1;
    reg_wdata = d;
    nmi_evt   = nmi;
    ae_evt    = ae;
    tick();
    reg_sel = 1'b0;
    reg_wr  = 1'b0;
    nmi_evt = 1'b0;
    ae_evt  = 1'b0;
  endtask

  task automatic pulse(logic nmi, logic ae);
    nmi_evt = nmi;
    ae_evt  = ae;
    tick();
    nmi_evt = 1'b0;
    ae_evt  = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    exp_out(4'b0000, 1'b1, "R1");
    rd(32'h0, "R1");

    wr(32'h1);
    exp_out(4'b1001, 1'b0, "R8");
    rd(32'h1, "R3");

    wr(32'hFFFF_FFFF);                       // R5: flag bits written as 1
    exp_out(4'b1001, 1'b0, "R5");
    rd(32'h1, "R2");

    pulse(1'b1, 1'b0);                       // R4
    exp_out(4'b0000, 1'b1, "R4");
    rd(32'h3, "R4");                         // arms the NMI flag

    pulse(1'b1, 1'b0);                       // new event drops the arm
    wr(32'h1);
    rd(32'h3, "R6");                         // unarmed write left it set
    wr(32'h1);
    exp_out(4'b1001, 1'b0, "R6");
    rd(32'h1, "R6");

    pulse(1'b1, 1'b0);
    rd(32'h3, "R7");
    wr(32'h1, 1'b1, 1'b0);                   // R7: set beats clear
    exp_out(4'b0000, 1'b1, "R7");
    wr(32'h1);
    rd(32'h3, "R7");
    wr(32'h1);
    rd(32'h1, "R7");

    wr(32'h0);
    exp_out(4'b0000, 1'b1, "R3");
    pulse(1'b1, 1'b0);                       // R4: sets while disabled
    rd(32'h2, "R4");
    wr(32'h0);
    rd(32'h0, "R4");

    wr(32'h1);
    pulse(1'b0, 1'b1);                       // R10
    exp_out(4'b0000, 1'b1, "R10");
    wr(32'h1);
    rd(32'h5, "R10");
    wr(32'h1);
    rd(32'h1, "R10");
    exp_out(4'b1001, 1'b0, "R10");

    ch_te = 4'b0000;
    tick();
    exp_out(4'b1011, 1'b0, "R8");
    ch_de = 4'b1111;
    ch_te = 4'b1000;
    tick();
    exp_out(4'b0111, 1'b0, "R8");

    wr(32'h0);
    exp_out(4'b0000, 1'b1, "R9");
    wr(32'h1);
    exp_out(4'b0111, 1'b0, "R9");

    pulse(1'b1, 1'b0);
    rd(32'h3, "R11");
    man_rst = 1'b1;
    tick();
    man_rst = 1'b0;
    exp_out(4'b0000, 1'b1, "R11");
    tick();
    push(0, 32'h0, "R11", 0);
    tick();
    push(0, 32'h0, "R2", 0);                 // held with no read strobe

    repeat (3) tick();
    if (sb.size() != 0) begin
      n_bad += sb.size();
      $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
    end
    summary();
  end
endmodule